// File: doc/BRIEF.md
# SBC Mode Control Register with Limp-Home Retention

This block is one 16-bit control register of a system basis chip. A serial front end, which is not part of this block, delivers a decoded command word together with a valid strobe and a write flag. The top three bits of the word select a register. When they match this register's constant address and the register is not locked, the word's payload updates the stored fields on the next clock edge. The read-back word is always available on `rd_data_o` and shows the current contents.

The stored fields are the operating mode (standby, sleep, or normal with the secondary supply off or on), the enable-pin control, the LIN slew select, the wake-bias control and the power-distribution threshold select. From these the block decodes the mode outputs, the EN pin level and the LIMP pin drive. A lock bit freezes every writable field until the next reset.

Two resets are used. `por_ni` is the power-on reset. `rst_ni` is the warm reset. The limp-home warning flag survives long enough for a warm reset to sample it. If the warning was set when a warm reset arrived, the limp-home control bit comes up set, and the LIMP pin is then pulled low.

Top module: `sbc_mode_reg`

## Requirements
- R1: Read-back bits 15:13 always equal the register address (default 3'b001). A command whose bits 15:13 differ from that address leaves every field unchanged.
- R2: An accepted write (valid, write flag, address match, unlocked, warm reset inactive) loads word bits 12:4 into the fields on the next rising clock edge. The field layout is: bit 12 lock, bits 11:10 mode, bit 9 warning, bit 8 limp control, bit 7 EN control, bit 6 LIN slow, bit 5 wake bias, bit 4 power-distribution select.
- R3: While the lock bit is 1, all writes are ignored, including writes to the lock bit itself. A warm reset or a power-on reset clears the lock bit.
- R4: Exactly one of `standby_o`, `sleep_o`, `normal_o` is high. Mode code 00 means standby, 01 sleep, 10 normal with the secondary supply off, and 11 normal with it on. `v2_on_o` is high only for code 11.
- R5: `en_o` is high only when the EN control bit is 1 and the mode is 10 or 11. In every other case it is low.
- R6: Read-back bits 3:0 are always 0000, whatever is written to them.
- R7: After a warm reset the warning bit is 1. The lock, mode, EN control, LIN slow, wake-bias and power-distribution fields are 0.
- R8: After a warm reset the limp control bit equals the value the warning bit held just before that reset began.
- R9: `limp_low_o` is 1 (drive LIMP low) exactly when the limp control bit is 1. When the bit is 0, the output requests release (floating).
- R10: After a power-on reset the warning bit is 1 and the limp control bit is 0, whatever they held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| rst_ni | input | 1 | Warm reset, active low |
| cmd_valid_i | input | 1 | Command word strobe |
| cmd_wr_i | input | 1 | Command is a write |
| cmd_word_i | input | 16 | Command word: address in 15:13, payload below |
| rd_data_o | output | 16 | Current register contents |
| standby_o | output | 1 | Mode is standby |
| sleep_o | output | 1 | Mode is sleep |
| normal_o | output | 1 | Mode is one of the normal modes |
| v2_on_o | output | 1 | Normal mode with secondary supply on |
| en_o | output | 1 | EN pin level |
| limp_low_o | output | 1 | 1: drive LIMP low, 0: release |
| lin_slow_o | output | 1 | LIN low-slope select |
| wbias_o | output | 1 | Wake-bias control |
| pdc_low_o | output | 1 | Lower power-distribution threshold select |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a 3-bit address and address value 001. With these values it can hit the register and also miss it with a foreign address such as 010, and it can set the reserved nibble to ones and see it read back as zero. It runs every mode code and two back-to-back warm resets, one with the warning cleared and one with it set, so both limp-control outcomes appear. It then checks that a power-on reset overrides an armed warning.

// File: rtl/sbc_mode_pkg.sv
package sbc_mode_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 3;
  localparam int RSVD_W = 4;

  typedef enum logic [1:0] {
    MD_STANDBY  = 2'b00,
    MD_SLEEP    = 2'b01,
    MD_NORM_OFF = 2'b10,
    MD_NORM_ON  = 2'b11
  } mode_e;

  localparam int NUM_MODES = 4;

  // payload bits 12:4 of the command word
  typedef struct packed {
    logic  lock;
    mode_e mode;
    logic  warn;
    logic  limp;
    logic  en_ctl;
    logic  lin_slow;
    logic  wbias;
    logic  pdc_low;
  } ctl_t;

  // fields without the limp-home pair
  typedef struct packed {
    logic  lock;
    mode_e mode;
    logic  en_ctl;
    logic  lin_slow;
    logic  wbias;
    logic  pdc_low;
  } gen_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/sbc_cmd_dec.sv
module sbc_cmd_dec
  import sbc_mode_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR = 3'b001
) (
  input  logic                     valid_i,
  input  logic                     wr_i,
  input  logic                     warm_rst_ni,
  input  logic [WORD_W-1:RSVD_W]   word_i,
  output logic                     hit_o,
  output ctl_t                     ctl_o
);
  localparam int ADDR_LSB = WORD_W - ADDR_W;

  logic addr_match;
  assign addr_match = (word_i[WORD_W-1:ADDR_LSB] == REG_ADDR);
  assign hit_o      = valid_i & wr_i & addr_match & warm_rst_ni;
  assign ctl_o      = ctl_t'(word_i[ADDR_LSB-1:RSVD_W]);
endmodule

// File: rtl/sbc_ctl_regs.sv
module sbc_ctl_regs
  import sbc_mode_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  gen_t wr_i,
  output logic we_o,
  output gen_t q_o
);
  gen_t q;

  assign we_o = hit_i & ~q.lock;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else if (we_o) q <= wr_i;
  end

  assign q_o = q;

  // R3: a locked register holds every field
  a_r3_lock_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q.lock |=> $stable(q));

  // R2: an accepted write lands on the next edge
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !q.lock) |=> (q == $past(wr_i)));
endmodule

// File: rtl/sbc_limp_ctl.sv
module sbc_limp_ctl (
  input  logic clk_i,
  input  logic por_ni,
  input  logic warm_rst_ni,
  input  logic we_i,
  input  logic warn_d_i,
  input  logic limp_d_i,
  output logic warn_o,
  output logic limp_o
);
  logic warn_q, limp_q, run_q;

  // only power-on clears asynchronously; warm reset is sampled so the
  // warning can be captured on its first cycle
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      warn_q <= 1'b1;
      limp_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      run_q <= warm_rst_ni;
      if (!warm_rst_ni) begin
        if (run_q) limp_q <= warn_q;
        warn_q <= 1'b1;
      end else if (we_i) begin
        warn_q <= warn_d_i;
        limp_q <= limp_d_i;
      end
    end
  end

  assign warn_o = warn_q;
  assign limp_o = limp_q;

  // R8: first warm-reset cycle transfers the warning into limp control
  a_r8_limp_capture: assert property (@(posedge clk_i) disable iff (!por_ni)
    (!warm_rst_ni && run_q) |=> (limp_q == $past(warn_q)) && warn_q);

  // R7: warning reads set while warm reset is held
  a_r7_warn_set: assert property (@(posedge clk_i) disable iff (!por_ni)
    !warm_rst_ni |=> warn_q);
endmodule

// File: rtl/sbc_pin_dec.sv
module sbc_pin_dec
  import sbc_mode_pkg::*;
(
  input  mode_e mode_i,
  input  logic  en_ctl_i,
  input  logic  limp_i,
  output logic  standby_o,
  output logic  sleep_o,
  output logic  normal_o,
  output logic  v2_on_o,
  output logic  en_o,
  output logic  limp_low_o
);
  logic [NUM_MODES-1:0] hit;

  for (genvar i = 0; i < NUM_MODES; i++) begin : g_mode
    assign hit[i] = (mode_i == mode_e'(i));
  end

  assign standby_o  = hit[MD_STANDBY];
  assign sleep_o    = hit[MD_SLEEP];
  assign normal_o   = hit[MD_NORM_OFF] | hit[MD_NORM_ON];
  assign v2_on_o    = hit[MD_NORM_ON];
  assign en_o       = en_ctl_i & normal_o;
  assign limp_low_o = limp_i;
endmodule

// File: rtl/sbc_mode_reg.sv
module sbc_mode_reg
  import sbc_mode_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR = 3'b001
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_wr_i,
  input  logic [WORD_W-1:0] cmd_word_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              standby_o,
  output logic              sleep_o,
  output logic              normal_o,
  output logic              v2_on_o,
  output logic              en_o,
  output logic              limp_low_o,
  output logic              lin_slow_o,
  output logic              wbias_o,
  output logic              pdc_low_o
);
  logic rst_all_n;
  logic hit, we;
  ctl_t wctl;
  gen_t wgen, gq;
  logic warn, limp;
  logic [RSVD_W-1:0] rsvd_rd;

  assign rst_all_n = por_ni & rst_ni;

  sbc_cmd_dec #(.REG_ADDR(REG_ADDR)) u_dec (
    .valid_i     (cmd_valid_i),
    .wr_i        (cmd_wr_i),
    .warm_rst_ni (rst_ni),
    .word_i      (cmd_word_i[WORD_W-1:RSVD_W]),
    .hit_o       (hit),
    .ctl_o       (wctl)
  );

  assign wgen = '{lock: wctl.lock, mode: wctl.mode, en_ctl: wctl.en_ctl,
                  lin_slow: wctl.lin_slow, wbias: wctl.wbias,
                  pdc_low: wctl.pdc_low};

  sbc_ctl_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_all_n),
    .hit_i  (hit),
    .wr_i   (wgen),
    .we_o   (we),
    .q_o    (gq)
  );

  sbc_limp_ctl u_limp (
    .clk_i       (clk_i),
    .por_ni      (por_ni),
    .warm_rst_ni (rst_ni),
    .we_i        (we),
    .warn_d_i    (wctl.warn),
    .limp_d_i    (wctl.limp),
    .warn_o      (warn),
    .limp_o      (limp)
  );

  sbc_pin_dec u_pins (
    .mode_i     (gq.mode),
    .en_ctl_i   (gq.en_ctl),
    .limp_i     (limp),
    .standby_o  (standby_o),
    .sleep_o    (sleep_o),
    .normal_o   (normal_o),
    .v2_on_o    (v2_on_o),
    .en_o       (en_o),
    .limp_low_o (limp_low_o)
  );

  // reserved nibble never reflects the written value
  assign rsvd_rd = cmd_word_i[RSVD_W-1:0] & '0;

  assign rd_data_o = {REG_ADDR, gq.lock, gq.mode, warn, limp,
                      gq.en_ctl, gq.lin_slow, gq.wbias, gq.pdc_low, rsvd_rd};

  assign lin_slow_o = gq.lin_slow;
  assign wbias_o    = gq.wbias;
  assign pdc_low_o  = gq.pdc_low;

  // R4: mode outputs are one-hot
  a_r4_one_mode: assert property (@(posedge clk_i) disable iff (!por_ni)
    $onehot({standby_o, sleep_o, normal_o}));

  // R5: EN only in a normal mode with its control bit set
  a_r5_en_gate: assert property (@(posedge clk_i) disable iff (!por_ni)
    en_o |-> (normal_o && rd_data_o[7]));

  // R9: LIMP drive follows the read-back control bit
  a_r9_limp_pin: assert property (@(posedge clk_i) disable iff (!por_ni)
    limp_low_o == rd_data_o[8]);

  // R1: a foreign address leaves the contents alone
  a_r1_foreign_addr: assert property (@(posedge clk_i) disable iff (!rst_all_n)
    (cmd_valid_i && cmd_word_i[WORD_W-1 -: ADDR_W] != REG_ADDR) |=> $stable(rd_data_o));
endmodule

// File: tb/sbc_mode_reg_test.sv
`timescale 1ns/1ps
module sbc_mode_reg_test;
  logic        clk_i = 1'b0;
  logic        por_ni = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_wr_i = 1'b0;
  logic [15:0] cmd_word_i = '0;
  logic [15:0] rd_data_o;
  logic standby_o, sleep_o, normal_o, v2_on_o, en_o, limp_low_o;
  logic lin_slow_o, wbias_o, pdc_low_o;

  always #2.5 clk_i = ~clk_i;

  sbc_mode_reg uut (.*);

  typedef struct {
    logic [15:0] rd;
    logic [8:0]  pins;
    string       req;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic       m_lock, m_warn, m_limp, m_en, m_lsc, m_wb, m_pdc;
  logic [1:0] m_mode;

  function automatic logic [15:0] exp_rd();
    return {3'b001, m_lock, m_mode, m_warn, m_limp, m_en, m_lsc, m_wb, m_pdc, 4'b0000};
  endfunction

  function automatic logic [8:0] exp_pins();
    return {m_mode == 2'b00, m_mode == 2'b01, m_mode[1], m_mode == 2'b11,
            m_en & m_mode[1], m_limp, m_lsc, m_wb, m_pdc};
  endfunction

  task automatic push(string req);
    item_t it;
    it.rd = exp_rd();
    it.pins = exp_pins();
    it.req = req;
    q.push_back(it);
  endtask

  task automatic clear_gen();
    m_lock = 0; m_mode = 2'b00; m_en = 0; m_lsc = 0; m_wb = 0; m_pdc = 0;
  endtask

  task automatic por(string req);
    @(negedge clk_i);
    por_ni = 0; rst_ni = 0;
    repeat (2) @(negedge clk_i);
    por_ni = 1; rst_ni = 1;
    @(negedge clk_i);
    clear_gen(); m_warn = 1; m_limp = 0;
    push(req);
  endtask

  task automatic warm(string req);
    @(negedge clk_i);
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    m_limp = m_warn; m_warn = 1; clear_gen();
    push(req);
  endtask

  // payload: {lock, mode[1:0], warn, limp, en, lsc, wbias, pdc}
  task automatic wr(logic [2:0] addr, logic [8:0] p, logic [3:0] rsvd, string req);
    @(negedge clk_i);
    cmd_valid_i = 1; cmd_wr_i = 1; cmd_word_i = {addr, p, rsvd};
    @(negedge clk_i);
    cmd_valid_i = 0; cmd_wr_i = 0;
    if (addr == 3'b001 && !m_lock)
      {m_lock, m_mode, m_warn, m_limp, m_en, m_lsc, m_wb, m_pdc} = p;
    push(req);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [8:0] act;
        it = q.pop_front();
        act = {standby_o, sleep_o, normal_o, v2_on_o, en_o, limp_low_o,
               lin_slow_o, wbias_o, pdc_low_o};
        n_chk++;
        if (rd_data_o !== it.rd || act !== it.pins) begin
          n_fail++;
          $display("FAIL %s: rd=%h pins=%b expected rd=%h pins=%b",
                   it.req, rd_data_o, act, it.rd, it.pins);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    por("R10 R1 R6 reset state");
    wr(3'b001, 9'b0_11_0_0_1_0_0_0, 4'h0, "R2 R5 normal v2 on with EN");
    wr(3'b010, 9'b1_11_1_1_1_1_1_1, 4'hF, "R1 foreign address ignored");
    for (int m = 0; m < 4; m++)
      wr(3'b001, {1'b0, 2'(m), 6'b1_0_1_0_0_0}, 4'h0, "R4 R5 mode sweep");
    wr(3'b001, 9'b0_01_0_1_0_1_1_1, 4'hF, "R9 R6 limp drive and reserved");
    wr(3'b001, 9'b0_10_0_0_1_0_0_0, 4'h0, "R2 limp release");
    warm("R7 R8 warm reset with warning clear");
    warm("R8 R9 warm reset with warning set");
    wr(3'b001, 9'b1_10_0_0_1_1_0_1, 4'h0, "R3 R2 lock set");
    wr(3'b001, 9'b0_00_1_1_0_0_1_0, 4'hA, "R3 write while locked");
    wr(3'b001, 9'b0_11_1_1_1_1_1_1, 4'h5, "R3 second write while locked");
    warm("R3 R8 warm reset clears lock");
    wr(3'b001, 9'b0_11_0_0_1_0_0_0, 4'h0, "R3 writable after reset");
    wr(3'b001, 9'b0_00_1_1_0_0_0_0, 4'h0, "R9 arm warning and limp");
    por("R10 power-on overrides warning");
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule